// File: doc/BRIEF.md
# Two-Stage Register Write-Enable Controller

This block guards a small bank of nonvolatile configuration registers. It sits behind a serial front end that has already decoded the bus into events: start, stop, a received byte, and a framing error. Each write transaction carries a device-select byte, a register address and one or more data bytes. A status register at a fixed address holds two unlock flags: a write-enable flag and a register-write-enable flag. Protected bytes pass to the shadow bank only after both flags have been set by two separate status writes, in order.

After that unlock, one transaction may write a burst of up to eight consecutive bytes. Each byte is forwarded as a write strobe to the shadow bank, and the address advances after every byte. A transaction that is closed cleanly by a stop starts a timed commit. While the commit runs, busy is held high. When it ends, a one-cycle done event fires and the register-write-enable flag is cleared, so each further change needs a new unlock.

Top module: `regwr_guard`

## Requirements
- R1: The first byte after a start is the select byte. Bits [7:1] must equal 7'b1101111. Bit 0 = 0 marks a write and bit 0 = 1 marks a read. A transaction with any other select byte is ignored.
- R2: A status write of 8'h02 sets `wel` in the cycle after the stop. `rwel` and `busy` are unaffected. The status register sits at address 8'h3F.
- R3: A status write of exactly 8'h06 sets `rwel` only while `wel` is already set. With `wel` clear it changes nothing. Any status value other than 8'h00, 8'h02 or 8'h06 (for example 8'h0E) changes nothing. `rwel` is never set while `wel` is clear.
- R4: A status write of 8'h00 clears both `wel` and `rwel`.
- R5: With `rwel` set and no commit running, each data byte aimed at an address in 0..NREG-1 produces a one-cycle `wr_stb`, with `wr_addr`/`wr_data`, in the cycle after the byte. The address auto-increments after every data byte.
- R6: A stop that closes a write transaction in which at least one byte was strobed raises `busy` in the next cycle. `busy` stays high for COMMIT_CYC cycles. As it falls, `commit_done` pulses for one cycle and `rwel` clears, while `wel` stays set.
- R7: Data bytes aimed at addresses outside the bank and other than the status address produce no strobe. A transaction that strobed nothing starts no commit.
- R8: A transaction that is aborted produces no commit and leaves both flags unchanged. An abort is any of: the framing-error input, a repeated start before the stop, or a ninth data byte. The ninth byte itself is not strobed.
- R9: Read transactions do not change `wel`, `rwel` or `busy`.
- R10: While `busy` is high, status writes are rejected and protected data bytes are not strobed.
- R11: Protected data bytes sent while `rwel` is clear are dropped silently. They produce no strobe and no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start condition seen on the bus |
| ev_stop | input | 1 | Stop condition seen on the bus |
| ev_byte | input | 1 | A complete byte is present on `byte_in` |
| ev_abort | input | 1 | Framing error (wrong bit count) in the current transaction |
| byte_in | input | 8 | Received byte |
| wel | output | 1 | Write-enable flag |
| rwel | output | 1 | Register-write-enable flag |
| busy | output | 1 | Nonvolatile commit in progress |
| wr_stb | output | 1 | Shadow-bank write strobe |
| wr_addr | output | AW | Shadow-bank register index |
| wr_data | output | 8 | Shadow-bank write data |
| commit_done | output | 1 | One-cycle pulse at the end of a commit |

## Verification
The hardest state to reach is a status or burst write that arrives while a commit is still counting. The stimulus gets there by a full unlock followed by a burst that runs past the end of the bank, so the partial strobing is exercised as well. A status clear and a protected write are then issued inside the busy window, which is set short for the bench. The abort paths are reached from a fully unlocked state, so that a wrongly started commit or a lost flag would show: a repeated start, the framing-error input, and a nine-byte burst. A behavioural model follows every cycle throughout.

// File: rtl/regwr_guard.sv
module regwr_guard #(
  parameter int NREG = 8,
  parameter int MAX_BURST = 8,
  parameter int COMMIT_CYC = 100000,
  parameter logic [7:0] STAT_ADDR = 8'h3F,
  parameter logic [6:0] DEV_ID = 7'b1101111,
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_byte,
  input  logic          ev_abort,
  input  logic [7:0]    byte_in,
  output logic          wel,
  output logic          rwel,
  output logic          busy,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          commit_done
);
  localparam int CW = $clog2(MAX_BURST + 2);
  localparam int TW = $clog2(COMMIT_CYC + 1);

  typedef enum logic [1:0] {P_IDLE, P_SEL, P_ADDR, P_DATA} phase_t;

  phase_t        phase;
  logic [7:0]    ptr, st_val;
  logic [CW-1:0] nbytes;
  logic          is_stat, hit, bad;
  logic [TW-1:0] tmr;

  wire sel_ok     = (byte_in[7:1] == DEV_ID) && !byte_in[0];
  wire in_bank    = {24'b0, ptr} < 32'(NREG);
  wire burst_full = nbytes >= CW'(MAX_BURST);
  wire st_ok      = is_stat && (nbytes == CW'(1)) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_IDLE; ptr <= '0; st_val <= '0; nbytes <= '0;
      is_stat <= 1'b0; hit <= 1'b0; bad <= 1'b0; tmr <= '0;
      wel <= 1'b0; rwel <= 1'b0; busy <= 1'b0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0; commit_done <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      commit_done <= 1'b0;
      if (ev_abort) begin
        phase <= P_IDLE;
      end else if (ev_start) begin
        phase <= P_SEL; nbytes <= '0; hit <= 1'b0; bad <= 1'b0;
      end else if (ev_stop) begin
        phase <= P_IDLE;
        if (phase == P_DATA && !bad) begin
          if (st_ok) begin
            case (st_val)
              8'h00: begin wel <= 1'b0; rwel <= 1'b0; end
              8'h02: wel <= 1'b1;
              8'h06: if (wel) rwel <= 1'b1;
              default: ;
            endcase
          end else if (!is_stat && hit && !busy) begin
            busy <= 1'b1;
            tmr  <= TW'(COMMIT_CYC - 1);
          end
        end
      end else if (ev_byte) begin
        case (phase)
          P_SEL:  phase <= sel_ok ? P_ADDR : P_IDLE;
          P_ADDR: begin
            ptr <= byte_in; is_stat <= (byte_in == STAT_ADDR); phase <= P_DATA;
          end
          P_DATA: begin
            ptr <= ptr + 8'd1;
            if (!burst_full) nbytes <= nbytes + CW'(1);
            if (is_stat) begin
              if (nbytes == '0) st_val <= byte_in;
              else bad <= 1'b1;
            end else if (burst_full) begin
              bad <= 1'b1;
            end else if (rwel && !busy && in_bank) begin
              wr_stb <= 1'b1; wr_addr <= ptr[AW-1:0]; wr_data <= byte_in; hit <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (busy) begin
        if (tmr == '0) begin
          busy <= 1'b0; rwel <= 1'b0; commit_done <= 1'b1;
        end else begin
          tmr <= tmr - TW'(1);
        end
      end
    end
  end

  AST_STB_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> rwel && !busy); // R11
  AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel); // R3
  AST_COMMIT_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !rwel && commit_done); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> !commit_done); // R6
  AST_COMMIT_FROM_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rwel); // R6
  AST_FLAGS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(wel)); // R10
endmodule

// File: tb/regwr_guard_test.sv
module regwr_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int CYC = 20;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, ev_byte = 0, ev_abort = 0;
  logic [7:0] byte_in = '0;
  logic wel, rwel, busy, wr_stb, commit_done;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  int checks = 0, fails = 0;

  regwr_guard #(.NREG(NREG), .COMMIT_CYC(CYC)) uut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte(ev_byte), .ev_abort(ev_abort), .byte_in(byte_in),
    .wel(wel), .rwel(rwel), .busy(busy), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .commit_done(commit_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_phase, m_ptr, m_n, m_st, m_left, m_addr, m_data;
  bit m_stat, m_hit, m_bad, m_wel, m_rwel, m_busy, m_stb, m_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_ptr = 0; m_n = 0; m_st = 0; m_left = 0;
      m_stat = 0; m_hit = 0; m_bad = 0; m_wel = 0; m_rwel = 0;
      m_busy = 0; m_stb = 0; m_done = 0; m_addr = 0; m_data = 0;
    end else begin
      bit pb, pw, pr;
      pb = m_busy; pw = m_wel; pr = m_rwel;
      m_stb = 0; m_done = 0;
      if (ev_abort) m_phase = 0;
      else if (ev_start) begin m_phase = 1; m_n = 0; m_hit = 0; m_bad = 0; end
      else if (ev_stop) begin
        if (m_phase == 3 && !m_bad) begin
          if (m_stat) begin
            if (m_n == 1 && !pb) begin
              if (m_st == 'h00) begin m_wel = 0; m_rwel = 0; end
              else if (m_st == 'h02) m_wel = 1;
              else if (m_st == 'h06 && pw) m_rwel = 1;
            end
          end else if (m_hit && !pb) begin m_busy = 1; m_left = CYC; end
        end
        m_phase = 0;
      end else if (ev_byte) begin
        if (m_phase == 1) m_phase = (byte_in == 8'hDE) ? 2 : 0;
        else if (m_phase == 2) begin m_ptr = byte_in; m_stat = (byte_in == 8'h3F); m_phase = 3; end
        else if (m_phase == 3) begin
          if (m_stat) begin if (m_n == 0) m_st = byte_in; else m_bad = 1; end
          else if (m_n >= 8) m_bad = 1;
          else if (pr && !pb && m_ptr < NREG) begin
            m_stb = 1; m_addr = m_ptr; m_data = byte_in; m_hit = 1;
          end
          if (m_n < 9) m_n++;
          m_ptr = (m_ptr + 1) % 256;
        end
      end
      if (pb) begin
        if (m_left == 1) begin m_busy = 0; m_rwel = 0; m_done = 1; end
        else m_left--;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(wel == m_wel, "R2 wel vs model", wel, m_wel);
    chk(rwel == m_rwel, "R3 rwel vs model", rwel, m_rwel);
    chk(busy == m_busy, "R6 busy vs model", busy, m_busy);
    chk(commit_done == m_done, "R6 commit_done vs model", commit_done, m_done);
    chk(wr_stb == m_stb, "R5 wr_stb vs model", wr_stb, m_stb);
    if (m_stb) begin
      chk(wr_addr == m_addr[2:0], "R5 wr_addr vs model", wr_addr, m_addr);
      chk(wr_data == m_data[7:0], "R5 wr_data vs model", wr_data, m_data);
    end
  end

  task automatic pulse(input int kind, input logic [7:0] d);
    @(negedge clk);
    ev_start = (kind == 0); ev_stop = (kind == 1);
    ev_byte = (kind == 2); ev_abort = (kind == 3); byte_in = d;
    @(negedge clk);
    ev_start = 0; ev_stop = 0; ev_byte = 0; ev_abort = 0;
  endtask

  task automatic xfer(input logic [7:0] sel, input logic [7:0] addr, input bq_t d);
    pulse(0, 0); pulse(2, sel); pulse(2, addr);
    foreach (d[i]) pulse(2, d[i]);
    pulse(1, 0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!wel && !rwel && !busy, "R2 reset flags clear", {wel, rwel, busy}, 0);
    // R11: protected bytes dropped while locked
    pulse(0, 0); pulse(2, 8'hDE); pulse(2, 8'h00); pulse(2, 8'hAA);
    chk(wr_stb == 0, "R11 no strobe while locked", wr_stb, 0);
    pulse(1, 0);
    chk(busy == 0, "R11 no commit while locked", busy, 0);
    xfer(8'hDE, 8'h3F, '{8'h06});
    chk(!wel && !rwel, "R3 06 with wel clear ignored", {wel, rwel}, 0);
    xfer(8'hA0, 8'h3F, '{8'h02});
    chk(wel == 0, "R1 foreign select ignored", wel, 0);
    xfer(8'hDE, 8'h3F, '{8'h02});
    chk(wel && !rwel && !busy, "R2 02 sets wel only", {wel, rwel, busy}, 3'b100);
    xfer(8'hDE, 8'h3F, '{8'h0E});
    chk(wel && !rwel, "R3 nonzero spare bits rejected", {wel, rwel}, 2'b10);
    xfer(8'hDE, 8'h3F, '{8'h06});
    chk(wel && rwel, "R3 06 after 02 sets both", {wel, rwel}, 2'b11);
    xfer(8'hDF, 8'h3F, '{8'h00, 8'h11});
    chk(wel && rwel && !busy, "R9 read leaves flags", {wel, rwel, busy}, 3'b110);
    pulse(0, 0); pulse(2, 8'hDE); pulse(2, 8'h20); pulse(2, 8'h11);
    chk(wr_stb == 0, "R7 undefined address no strobe", wr_stb, 0);
    pulse(1, 0);
    chk(busy == 0, "R7 no commit without strobe", busy, 0);
    pulse(0, 0); pulse(2, 8'hDE); pulse(2, 8'h02); pulse(2, 8'h55);
    chk(wr_stb && wr_addr == 2 && wr_data == 8'h55, "R5 strobe addr 2",
        {wr_stb, wr_addr, wr_data}, {1'b1, 3'd2, 8'h55});
    pulse(0, 0); pulse(1, 0);
    chk(!busy && rwel, "R8 repeated start aborts", {busy, rwel}, 2'b01);
    pulse(0, 0); pulse(2, 8'hDE); pulse(2, 8'h00); pulse(2, 8'h11);
    pulse(3, 0); pulse(1, 0);
    chk(!busy && rwel, "R8 framing error aborts", {busy, rwel}, 2'b01);
    pulse(0, 0); pulse(2, 8'hDE); pulse(2, 8'h00);
    for (int i = 0; i < 9; i++) begin
      pulse(2, 8'h30 + 8'(i));
      if (i < 8) chk(wr_stb && wr_addr == 3'(i), "R5 burst auto-increment",
                     {wr_stb, wr_addr}, {1'b1, 3'(i)});
      else chk(wr_stb == 0, "R8 ninth byte not strobed", wr_stb, 0);
    end
    pulse(1, 0);
    chk(!busy && rwel, "R8 ninth byte aborts commit", {busy, rwel}, 2'b01);
    pulse(0, 0); pulse(2, 8'hDE); pulse(2, 8'h06);
    pulse(2, 8'h01); pulse(2, 8'h02); pulse(2, 8'h03);
    chk(wr_stb == 0, "R7 bytes past bank end dropped", wr_stb, 0);
    pulse(1, 0);
    chk(busy == 1, "R6 commit starts after stop", busy, 1);
    xfer(8'hDE, 8'h3F, '{8'h00});
    chk(wel && rwel, "R10 status write rejected while busy", {wel, rwel}, 2'b11);
    pulse(0, 0); pulse(2, 8'hDE); pulse(2, 8'h00); pulse(2, 8'h77);
    chk(wr_stb == 0, "R10 no strobe while busy", wr_stb, 0);
    pulse(1, 0);
    while (busy) @(negedge clk);
    chk(commit_done && !rwel && wel, "R6 commit end relocks",
        {commit_done, rwel, wel}, 3'b101);
    xfer(8'hDE, 8'h3F, '{8'h06});
    xfer(8'hDE, 8'h04, '{8'h9C});
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == CYC, "R6 busy length", n, CYC);
    xfer(8'hDE, 8'h3F, '{8'h06});
    xfer(8'hDE, 8'h3F, '{8'h00});
    chk(!wel && !rwel, "R4 00 clears both", {wel, rwel}, 0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule